// File: doc/BRIEF.md
# Prescaled Clock Divider with Glitch-Free Output Gating

This block makes two slower clocks from one master oscillator. The first stage divides by 1, 2 or 4 and produces the reference clock. The second stage counts reference periods and divides again by any ratio from 1 to 513 to make the main clock. Every output is a registered level on `clk_i`. One `clk_i` cycle stands for one half-period of the modelled master oscillator, so even a divide-by-one reference is a true square wave. The reference therefore has a period of 2·M cycles and the main clock a period of 2·M·N cycles.

An enable input controls the main clock. It may change at any time relative to the clock. The block passes it through a two-flop synchronizer, and the divider acts on it only at rising edges of the reference. When the enable is withdrawn, a high pulse already in progress runs to its normal end, and a low output simply stays low. While the main clock is stopped, its counter is held at zero, so every restart begins from the same phase. The reference keeps running whatever the enable does.

A force input overrides both ratios with their largest values. Any ratio change, forced or programmed, is applied only at a counter boundary, so no pulse is ever shortened.

Top module: `pscdiv_top`

## Requirements
- R1: `psc_sel_i` picks M. Code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4. `ref_o` is a square wave with a period of 2·M cycles and a high time of M cycles.
- R2: `div_n_i` holds N as a plain binary value. A value of 0 acts as 1, and any value above 513 acts as 513. `main_o` has a period of 2·M·N cycles.
- R3: When N is greater than 1, `main_o` stays high for floor(N/2)·2·M cycles of each period. When N equals 1, `main_o` follows `ref_o`, high for M cycles and low for M cycles.
- R4: `main_o` rises only on the same clock edge on which `ref_o` rises.
- R5: After `oe_i` goes high with the block stopped, the first sample of `main_o` high appears between 3 and 2·M+2 clock edges later.
- R6: If `oe_i` drops while `main_o` is high, that pulse keeps its full high time. After it ends, `main_o` stays low.
- R7: If `oe_i` drops while `main_o` is low and well before the next rise, `main_o` produces no further pulse. A rise of `main_o` requires the synchronized enable to have been high in the cycle before.
- R8: `ref_o` keeps toggling at its programmed rate while `oe_i` is low.
- R9: `held_low_o` is 1 exactly while the main divider is stopped. During that time `main_o` is 0 and the divider count sits at zero.
- R10: While `force_max_i` is 1, the block behaves as if M = 4 and N = 513, giving a main period of 4104 cycles, a main high time of 2048 cycles and a reference period of 8 cycles.
- R11: A new N is taken up only when the divider count wraps. Every main pulse after a change has either the old high time or the new one.
- R12: While `rst_i` is high, `ref_o` and `main_o` are 0 and `held_low_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; one cycle is one half-period of the master oscillator |
| rst_i | input | 1 | Synchronous active-high reset; loads the current ratios |
| psc_sel_i | input | 2 | Prescale select (0: /1, 1: /2, 2 or 3: /4) |
| div_n_i | input | 10 | Main divide ratio N (0 treated as 1, clamped to 513) |
| oe_i | input | 1 | Main output enable, asynchronous |
| force_max_i | input | 1 | Override both ratios with M = 4 and N = 513 |
| ref_o | output | 1 | Reference clock, master divided by M |
| main_o | output | 1 | Gated main clock, master divided by M·N |
| held_low_o | output | 1 | High while the main divider is stopped and its output held low |

## Verification
Some properties hold in every cycle, and the bound checker enforces those continuously. A main rise always coincides with a reference rise, and it always follows a high synchronized enable. The stopped flag implies a low output and a zeroed count, and the count stays below the active ratio.

Other behaviour spans many cycles and only the bench scenarios can show it. This covers the exact periods and high times for each prescale and divide pair, and the clamping of out-of-range N. It also covers the full length of a pulse interrupted by a disable, the absence of pulses after a disable during the low phase, and the restart latency window across several enable phases. The force override and the old-or-new pulse widths around a ratio change are likewise checked by the bench.

// File: rtl/pscdiv_pkg.sv
package pscdiv_pkg;

    // Widths and limits shared by every part of the divider
    localparam int DIV_W   = 10;
    localparam int DIV_MAX = 513;
    localparam int PSC_W   = 3;
    localparam int PSC_MAX = 4;

    // Prescaler output carried as one bundle: level plus edge strobes
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pclk_t;

    typedef enum logic [1:0] {
        PSC_BY1  = 2'd0,
        PSC_BY2  = 2'd1,
        PSC_BY4  = 2'd2,
        PSC_BY4B = 2'd3
    } psc_sel_e;

    // Prescale ratio from the select code, with the override applied
    function automatic logic [PSC_W-1:0] psc_ratio(input logic [1:0] sel,
                                                   input logic force_max);
        if (force_max) return PSC_W'(PSC_MAX);
        case (psc_sel_e'(sel))
            PSC_BY1: return PSC_W'(1);
            PSC_BY2: return PSC_W'(2);
            default: return PSC_W'(PSC_MAX);
        endcase
    endfunction

    // Divide ratio with the zero and upper-limit rules and the override
    function automatic logic [DIV_W-1:0] div_ratio(input logic [DIV_W-1:0] n,
                                                   input logic force_max);
        if (force_max || n > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
        if (n == '0) return DIV_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/pscdiv_sync.sv
module pscdiv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pscdiv_prescale.sv
module pscdiv_prescale
    import pscdiv_pkg::*;
#(
    parameter int RW = PSC_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [RW-1:0] ratio_i,
    output pclk_t         pclk_o
);

    logic [RW-1:0] ratio_q;
    logic [RW-1:0] cnt_q;
    logic          level_q;
    logic          last;

    // Each half-period of the prescaled clock lasts ratio_q cycles
    assign last = (cnt_q == ratio_q - RW'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ratio_q <= ratio_i;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (last) begin
            cnt_q   <= '0;
            level_q <= ~level_q;
            // A new ratio starts only with a fresh high half
            if (!level_q) ratio_q <= ratio_i;
        end else begin
            cnt_q <= cnt_q + RW'(1);
        end
    end

    always_comb begin
        pclk_o.level = level_q;
        pclk_o.rise  = last & ~level_q;
        pclk_o.fall  = last &  level_q;
    end

endmodule

// File: rtl/pscdiv_divider.sv
module pscdiv_divider
    import pscdiv_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          en_i,
    input  logic [DW-1:0] n_req_i,
    output logic          main_o,
    output logic          run_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] n_cur_o
);

    logic [DW-1:0] n_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cnt_nxt;
    logic [DW-1:0] half;
    logic          run_q;
    logic          main_q;
    logic          single;
    logic          wrap;
    logic          next_hi;
    logic          stop;

    always_comb begin
        half    = n_q >> 1;
        single  = (n_q == DW'(1));
        wrap    = (cnt_q == n_q - DW'(1));
        cnt_nxt = wrap ? '0 : cnt_q + DW'(1);
        next_hi = single | (cnt_nxt < half);
        // Halt unless a high pulse is still owed its remaining periods
        stop    = ~en_i & ~(main_q & ~single & (cnt_nxt < half));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            n_q    <= n_req_i;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            main_q <= 1'b0;
        end else if (rise_i) begin
            if (!run_q) begin
                n_q    <= n_req_i;
                cnt_q  <= '0;
                run_q  <= en_i;
                main_q <= en_i;
            end else if (stop) begin
                run_q  <= 1'b0;
                cnt_q  <= '0;
                main_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_nxt;
                main_q <= next_hi;
                if (wrap) n_q <= n_req_i;
            end
        end else if (fall_i && single) begin
            main_q <= 1'b0;
        end
    end

    assign main_o  = main_q;
    assign run_o   = run_q;
    assign cnt_o   = cnt_q;
    assign n_cur_o = n_q;

endmodule

// File: rtl/pscdiv_top.sv
module pscdiv_top
    import pscdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       psc_sel_i,
    input  logic [DIV_W-1:0] div_n_i,
    input  logic             oe_i,
    input  logic             force_max_i,
    output logic             ref_o,
    output logic             main_o,
    output logic             held_low_o
);

    logic [PSC_W-1:0] m_req;
    logic [DIV_W-1:0] n_req;
    pclk_t            pclk;
    logic             en_sync;
    logic             run;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] n_active;

    assign m_req = psc_ratio(psc_sel_i, force_max_i);
    assign n_req = div_ratio(div_n_i, force_max_i);

    pscdiv_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (oe_i),
        .q_o   (en_sync)
    );

    pscdiv_prescale #(
        .RW (PSC_W)
    ) u_psc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ratio_i (m_req),
        .pclk_o  (pclk)
    );

    pscdiv_divider #(
        .DW (DIV_W)
    ) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rise_i  (pclk.rise),
        .fall_i  (pclk.fall),
        .en_i    (en_sync),
        .n_req_i (n_req),
        .main_o  (main_o),
        .run_o   (run),
        .cnt_o   (div_cnt),
        .n_cur_o (n_active)
    );

    assign ref_o      = pclk.level;
    assign held_low_o = ~run;

endmodule

// File: rtl/pscdiv_chk.sv
module pscdiv_chk
    import pscdiv_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             ref_o,
    input logic             main_o,
    input logic             held_low_o,
    input logic             en_sync,
    input logic [DIV_W-1:0] div_cnt,
    input logic [DIV_W-1:0] n_active
);

    // R4
    main_rise_aligned_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(main_o) |-> $rose(ref_o));

    // R7
    main_rise_enabled_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(main_o) |-> $past(en_sync));

    // R9
    held_output_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        held_low_o |-> !main_o);

    // R9
    held_count_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        held_low_o |-> (div_cnt == '0));

    // R2
    count_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        div_cnt < n_active);

endmodule

bind pscdiv_top pscdiv_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ref_o      (ref_o),
    .main_o     (main_o),
    .held_low_o (held_low_o),
    .en_sync    (en_sync),
    .div_cnt    (div_cnt),
    .n_active   (n_active)
);

// File: tb/sim_pscdiv_top.sv
module sim_pscdiv_top;

    logic       clk  = 1'b0;
    logic       rst  = 1'b1;
    logic [1:0] sel  = 2'd0;
    logic [9:0] nval = 10'd1;
    logic       oe   = 1'b1;
    logic       frc  = 1'b0;
    logic       ref_w;
    logic       main_w;
    logic       held_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // columns: select code, N input, main period, main high, ref period
    localparam int NVEC = 9;
    localparam int VEC [NVEC][5] = '{
        '{0,   1,    2,    1, 2},
        '{0,   2,    4,    2, 2},
        '{1,   3,   12,    4, 4},
        '{2,   5,   40,   16, 8},
        '{1,   0,    4,    2, 4},
        '{3,   7,   56,   24, 8},
        '{0, 513, 1026,  512, 2},
        '{2, 900, 4104, 2048, 8},
        '{1,  10,   40,   20, 4}
    };

    always #10 clk = ~clk;

    pscdiv_top u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .psc_sel_i   (sel),
        .div_n_i     (nval),
        .oe_i        (oe),
        .force_max_i (frc),
        .ref_o       (ref_w),
        .main_o      (main_w),
        .held_low_o  (held_w)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic pick(input bit use_ref);
        return use_ref ? ref_w : main_w;
    endfunction

    // Measure one fresh pulse: cycles high and full period, sampled on negedges
    task automatic measure(input bit use_ref, output int hi, output int per);
        int t;
        t   = 0;
        hi  = -1;
        per = -1;
        while (pick(use_ref) !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        while (pick(use_ref) !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
        if (t >= 20000) return;
        hi = 0;
        while (pick(use_ref) === 1'b1 && hi < 20000) begin @(negedge clk); hi++; end
        per = hi;
        while (pick(use_ref) === 1'b0 && per < 20000) begin @(negedge clk); per++; end
    endtask

    task automatic count_highs(input int cycles, output int highs);
        highs = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (main_w !== 1'b0) highs++;
        end
    endtask

    initial begin
        int hi;
        int per;
        int k;
        int highs;

        // Reset state
        repeat (2) @(negedge clk);
        check("R12 ref_o during reset", int'(ref_w), 0);
        check("R12 main_o during reset", int'(main_w), 0);
        check("R12 held_low_o during reset", int'(held_w), 1);

        // Table of ratio settings
        for (int i = 0; i < NVEC; i++) begin
            sel  = 2'(VEC[i][0]);
            nval = 10'(VEC[i][1]);
            oe   = 1'b1;
            frc  = 1'b0;
            do_reset();
            measure(1'b0, hi, per);
            check($sformatf("R2 main period vec%0d", i), per, VEC[i][2]);
            check($sformatf("R3 main high time vec%0d", i), hi, VEC[i][3]);
            check($sformatf("R4 ref_o high at main rise vec%0d", i), int'(ref_w), 1);
            measure(1'b1, hi, per);
            check($sformatf("R1 ref period vec%0d", i), per, VEC[i][4]);
            check($sformatf("R1 ref high time vec%0d", i), hi, VEC[i][4] / 2);
        end

        // Reference runs while the main output is disabled
        sel = 2'd1; nval = 10'd3; oe = 1'b0;
        do_reset();
        count_highs(60, highs);
        check("R8 main_o silent while disabled", highs, 0);
        measure(1'b1, hi, per);
        check("R8 ref period while disabled", per, 4);
        check("R9 held_low_o while disabled", int'(held_w), 1);

        // Restart latency across several enable phases
        sel = 2'd2; nval = 10'd5; oe = 1'b0;
        do_reset();
        for (int off = 0; off < 8; off++) begin
            repeat (off + 5) @(negedge clk);
            oe = 1'b1;
            k  = 0;
            while (main_w !== 1'b1 && k < 50) begin @(negedge clk); k++; end
            check($sformatf("R5 restart latency %0d in window", k), int'(k >= 3 && k <= 10), 1);
            check("R9 held_low_o clear while running", int'(held_w), 0);
            check("R4 ref_o high at restart", int'(ref_w), 1);
            oe = 1'b0;
            repeat (80) @(negedge clk);
            check("R9 held_low_o set after disable", int'(held_w), 1);
        end

        // Disable in the middle of a high pulse
        sel = 2'd1; nval = 10'd8; oe = 1'b1;
        do_reset();
        measure(1'b0, hi, per);
        repeat (3) @(negedge clk);
        oe = 1'b0;
        hi = 4;
        while (main_w === 1'b1 && hi < 100) begin
            @(negedge clk);
            if (main_w === 1'b1) hi++;
        end
        check("R6 interrupted pulse keeps full width", hi, 16);
        count_highs(100, highs);
        check("R6 output low after interrupted pulse", highs, 0);
        check("R9 held_low_o after interrupted pulse", int'(held_w), 1);

        // Disable during the low phase
        sel = 2'd2; nval = 10'd5; oe = 1'b1;
        do_reset();
        measure(1'b0, hi, per);
        while (main_w === 1'b1) @(negedge clk);
        oe = 1'b0;
        count_highs(120, highs);
        check("R7 no pulse after disable in low phase", highs, 0);
        check("R9 held_low_o after low-phase disable", int'(held_w), 1);

        // Ratio change mid-run
        sel = 2'd0; nval = 10'd6; oe = 1'b1;
        do_reset();
        measure(1'b0, hi, per);
        check("R11 baseline high time", hi, 6);
        repeat (3) @(negedge clk);
        nval = 10'd4;
        for (int p = 0; p < 3; p++) begin
            measure(1'b0, hi, per);
            check("R11 pulse width old or new", int'(hi == 6 || hi == 4), 1);
        end
        measure(1'b0, hi, per);
        check("R11 new period", per, 8);
        check("R11 new high time", hi, 4);

        // Force to maximum ratios
        sel = 2'd0; nval = 10'd3; oe = 1'b1;
        do_reset();
        frc = 1'b1;
        measure(1'b0, hi, per);
        measure(1'b0, hi, per);
        check("R10 forced main period", per, 4104);
        check("R10 forced main high time", hi, 2048);
        measure(1'b1, hi, per);
        check("R10 forced ref period", per, 8);
        check("R10 forced ref high time", hi, 4);
        frc = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule